// File: doc/BRIEF.md
# Affinity-Routed SGI Dispatch Unit

This block turns a software-generated interrupt request, written as one 64-bit word by one of several cores, into set-pending strobes for the cores that the word selects. The word is decoded into several fields: an interrupt number, a routing-mode bit, three upper affinity levels and a 16-bit level-0 target list.

In targeted mode, a core is selected when its upper affinity levels equal the requested ones and its level-0 bit is set in the list. In broadcast mode, every core except the requester is selected.

The unit walks the per-core affinity table one core per clock, in ascending index order. For every selected core it emits a one-cycle strobe together with the interrupt number. In targeted mode it keeps a working copy of the target list and clears each served bit. The walk stops as soon as that copy is empty. A completion pulse is raised only when at least one core was flagged. The request port refuses new requests while a walk is running. Reads of the write-only request register raise an error pulse and nothing else.

Top module: `sgi_route_unit`

## Requirements
- R1: A read request (req_valid=1, req_write=0) accepted while idle produces a one-cycle req_err pulse on the next cycle. It starts no scan, raises no strobe and raises no done.
- R2: Field layout of req_data: target list [15:0], level-1 affinity [23:16], interrupt number [27:24], level-2 affinity [39:32], broadcast bit 40, level-3 affinity [55:48]. Every other bit has no effect on the result.
- R3: In targeted mode (bit 40 = 0), core c is strobed only if its levels 1, 2 and 3 equal the requested levels and target-list bit L is set, where L is its level-0 value. In core_aff, core c occupies bits [c*32 +: 32]: level 0 in [7:0], level 1 in [15:8], level 2 in [23:16] and level 3 in [31:24].
- R4: In broadcast mode (bit 40 = 1), every core except req_core is strobed, whatever the target list and affinity fields hold.
- R5: Cores are examined one per cycle in ascending index. A targeted scan ends in the cycle in which the working list becomes empty, and an empty list at the start gives a scan of one cycle. Otherwise a scan lasts NUM_CORES cycles.
- R6: pend_strobe has at most one bit set per cycle. Each strobe lasts one cycle, and pend_sgi carries the decoded interrupt number while a strobe is high. Strobes appear only as a result of a scan.
- R7: done pulses for one cycle, on the cycle after the final scan cycle, only if at least one core was strobed during that scan.
- R8: busy is high for exactly the cycles of a scan, and req_ready is low during them. Requests offered while busy are not taken (a read offered then raises no req_err). An accepted write starts the scan on the next cycle.
- R9: After reset the unit is idle: req_ready=1, busy=0, and no strobe, done or req_err is raised.
- R10: In targeted mode, a core whose level-0 value is 16 or more is never strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_core | input | $clog2(NUM_CORES) | Index of requesting core |
| req_data | input | 64 | Written request word |
| core_aff | input | NUM_CORES*32 | Packed per-core affinity levels 0..3 |
| req_ready | output | 1 | Request port can accept |
| req_err | output | 1 | Illegal read pulse |
| busy | output | 1 | Scan in progress |
| pend_strobe | output | NUM_CORES | One-cycle set-pending strobe per core |
| pend_sgi | output | 4 | Interrupt number with the strobe |
| done | output | 1 | Completion pulse when any core was flagged |

## Verification
Some properties are checked by the assertions on every cycle:
- at most one strobe per cycle, and strobes and done arriving only out of a scan;
- a read turning into an error pulse without a scan;
- an accepted write starting a scan, and requests offered while busy producing nothing;
- the sender never being strobed in broadcast mode.

Other properties only the directed scenarios can show, because they depend on the affinity table and on what the request asked for:
- which cores a given word selects;
- that ignored bits change nothing;
- the exact scan length under early exit;
- that a request matching nothing gives no completion.

// File: rtl/sgi_route_pkg.sv
package sgi_route_pkg;
    localparam int AFF_W     = 8;
    localparam int LIST_W    = 16;
    localparam int SGI_W     = 4;
    localparam int CORE_AFFW = 4 * AFF_W;
    localparam int UPPER_W   = 3 * AFF_W;

    // request word field positions
    localparam int LIST_LSB  = 0;
    localparam int AFF1_LSB  = 16;
    localparam int SGI_LSB   = 24;
    localparam int AFF2_LSB  = 32;
    localparam int BCAST_BIT = 40;
    localparam int AFF3_LSB  = 48;

    typedef struct packed {
        logic [SGI_W-1:0]   sgi;
        logic               bcast;
        logic [LIST_W-1:0]  tlist;
        logic [UPPER_W-1:0] upper;   // {aff3, aff2, aff1}
    } sgi_req_t;
endpackage

// File: rtl/sgi_req_decode.sv
module sgi_req_decode
    import sgi_route_pkg::*;
(
    input  logic [63:0] word,
    output sgi_req_t    fields
);
    always_comb begin
        fields.sgi   = word[SGI_LSB +: SGI_W];
        fields.bcast = word[BCAST_BIT];
        fields.tlist = word[LIST_LSB +: LIST_W];
        fields.upper = {word[AFF3_LSB +: AFF_W], word[AFF2_LSB +: AFF_W],
                        word[AFF1_LSB +: AFF_W]};
    end
endmodule

// File: rtl/sgi_aff_match.sv
module sgi_aff_match
    import sgi_route_pkg::*;
#(
    parameter int NUM_CORES = 8
) (
    input  logic [NUM_CORES*CORE_AFFW-1:0] core_aff,
    input  logic [UPPER_W-1:0]             upper,
    input  logic [LIST_W-1:0]              tlist,
    output logic [NUM_CORES-1:0]           hit_vec,
    output logic [NUM_CORES-1:0][3:0]      lvl0
);
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic [AFF_W-1:0]   a0;
        logic [UPPER_W-1:0] up;
        logic               in_range;
        assign a0       = core_aff[c*CORE_AFFW +: AFF_W];
        assign up       = core_aff[c*CORE_AFFW + AFF_W +: UPPER_W];
        assign in_range = (a0 < AFF_W'(LIST_W));
        assign lvl0[c]  = a0[3:0];
        assign hit_vec[c] = in_range && (up == upper) && tlist[a0[3:0]];
    end
endmodule

// File: rtl/sgi_route_unit.sv
module sgi_route_unit
    import sgi_route_pkg::*;
#(
    parameter int NUM_CORES = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic                           req_write,
    input  logic [$clog2(NUM_CORES)-1:0]   req_core,
    input  logic [63:0]                    req_data,
    input  logic [NUM_CORES*CORE_AFFW-1:0] core_aff,
    output logic                           req_ready,
    output logic                           req_err,
    output logic                           busy,
    output logic [NUM_CORES-1:0]           pend_strobe,
    output logic [SGI_W-1:0]               pend_sgi,
    output logic                           done
);
    localparam int IDX_W = $clog2(NUM_CORES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CORES - 1);

    typedef struct packed {
        logic                 scan;
        logic [IDX_W-1:0]     idx;
        logic [IDX_W-1:0]     sender;
        logic                 bcast;
        logic [LIST_W-1:0]    tlist;
        logic [UPPER_W-1:0]   upper;
        logic [SGI_W-1:0]     sgi;
        logic                 any;
        logic [NUM_CORES-1:0] strobe;
        logic                 done;
        logic                 err;
    } state_t;

    state_t st_d, st_q;

    sgi_req_t                  fld;
    logic [NUM_CORES-1:0]      hit_vec;
    logic [NUM_CORES-1:0][3:0] lvl0;

    sgi_req_decode dec_i (
        .word   (req_data),
        .fields (fld)
    );

    sgi_aff_match #(.NUM_CORES(NUM_CORES)) match_i (
        .core_aff (core_aff),
        .upper    (st_q.upper),
        .tlist    (st_q.tlist),
        .hit_vec  (hit_vec),
        .lvl0     (lvl0)
    );

    always_comb begin
        logic hit;
        logic finish;
        st_d        = st_q;
        st_d.strobe = '0;
        st_d.done   = 1'b0;
        st_d.err    = 1'b0;
        hit         = 1'b0;
        finish      = 1'b0;
        if (!st_q.scan) begin
            if (req_valid) begin
                if (req_write) begin
                    st_d.scan   = 1'b1;
                    st_d.idx    = '0;
                    st_d.sender = req_core;
                    st_d.bcast  = fld.bcast;
                    st_d.tlist  = fld.tlist;
                    st_d.upper  = fld.upper;
                    st_d.sgi    = fld.sgi;
                    st_d.any    = 1'b0;
                end else begin
                    st_d.err = 1'b1;
                end
            end
        end else begin
            hit = st_q.bcast ? (st_q.idx != st_q.sender) : hit_vec[st_q.idx];
            if (hit) begin
                st_d.strobe[st_q.idx] = 1'b1;
                st_d.any = 1'b1;
                if (!st_q.bcast)
                    st_d.tlist[lvl0[st_q.idx]] = 1'b0;
            end
            finish = (st_q.idx == LAST_IDX) || (!st_q.bcast && st_d.tlist == '0);
            if (finish) begin
                st_d.scan = 1'b0;
                st_d.done = st_d.any;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready   = !st_q.scan;
    assign busy        = st_q.scan;
    assign pend_strobe = st_q.strobe;
    assign pend_sgi    = st_q.sgi;
    assign done        = st_q.done;
    assign req_err     = st_q.err;

    // R6
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_strobe));
    // R6
    strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_strobe) |-> $past(busy));
    // R7
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));
    // R1
    read_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_ready) |=> (req_err && !busy && pend_strobe == '0));
    // R8
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_ready) |=> busy);
    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> !req_err);
    // R4
    bcast_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_q.scan && st_q.bcast) |-> !pend_strobe[$past(st_q.sender)]);
endmodule

// File: tb/sgi_route_unit_tb_top.sv
`timescale 1ns/1ps
module sgi_route_unit_tb_top;
    localparam int N  = 8;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [IW-1:0] req_core = '0;
    logic [63:0]   req_data = '0;
    logic [N*32-1:0] core_aff;
    logic          req_ready, req_err, busy, done;
    logic [N-1:0]  pend_strobe;
    logic [3:0]    pend_sgi;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    sgi_route_unit #(.NUM_CORES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_core(req_core), .req_data(req_data), .core_aff(core_aff),
        .req_ready(req_ready), .req_err(req_err), .busy(busy),
        .pend_strobe(pend_strobe), .pend_sgi(pend_sgi), .done(done)
    );

    // affinity table: level3=0x0A, level2=0x05, level1 = 1 (cores 0-3) or 2 (4-7),
    // level0 = c%4, except core 7 whose level0 is 19
    function automatic logic [7:0] a0_of(int c);
        return (c == 7) ? 8'd19 : 8'(c % 4);
    endfunction
    function automatic logic [7:0] a1_of(int c);
        return (c < 4) ? 8'd1 : 8'd2;
    endfunction

    initial begin
        for (int c = 0; c < N; c++)
            core_aff[c*32 +: 32] = {8'h0A, 8'h05, a1_of(c), a0_of(c)};
    end

    function automatic logic [63:0] mk(logic [3:0] sgi, logic bc, logic [15:0] list,
                                        logic [7:0] a1, logic [7:0] a2, logic [7:0] a3,
                                        logic junk);
        logic [63:0] d = '0;
        d[15:0] = list; d[23:16] = a1; d[27:24] = sgi;
        d[39:32] = a2; d[40] = bc; d[55:48] = a3;
        if (junk) begin d[31:28] = 4'hF; d[47:41] = 7'h7F; d[63:56] = 8'hFF; end
        return d;
    endfunction

    task automatic chk(string rq, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // expected result derived from the requirements
    task automatic model(input logic [63:0] d, input int snd,
                         output int mask, output int cyc);
        logic [15:0] list = d[15:0];
        logic bc = d[40];
        mask = 0; cyc = 0;
        for (int c = 0; c < N; c++) begin
            logic m;
            cyc = c + 1;
            if (bc) m = (c != snd);
            else begin
                m = (a0_of(c) < 16) && (a1_of(c) == d[23:16]) && (d[39:32] == 8'h05)
                    && (d[55:48] == 8'h0A) && list[a0_of(c)];
                if (m) list[a0_of(c)] = 1'b0;
            end
            if (m) mask |= (1 << c);
            if (!bc && list == 0) break;
        end
    endtask

    // offer a write; optionally offer reads while busy; observe the whole scan
    task automatic run_write(string rq, logic [63:0] d, int snd, logic poke_busy);
        int exp_mask, exp_cyc;
        int got_mask = 0, cyc = 0, dones = 0, multi = 0, sgi_bad = 0, order_bad = 0;
        int errs = 0, rdy_bad = 0, last = -1, done_late = 0;
        model(d, snd, exp_mask, exp_cyc);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_data = d; req_core = IW'(snd);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        for (int k = 0; k < N + 3; k++) begin
            if (k > 0) @(negedge clk);
            if (poke_busy) begin
                req_valid = (k < 2) && busy;
                req_write = 1'b0;
            end
            if (busy) cyc++;
            if (req_ready == busy) rdy_bad++;
            if (req_err) errs++;
            if ($countones(pend_strobe) > 1) multi++;
            if (pend_strobe != 0) begin
                if (pend_sgi != d[27:24]) sgi_bad++;
                for (int c = 0; c < N; c++)
                    if (pend_strobe[c]) begin
                        if (c <= last) order_bad++;
                        last = c;
                    end
                got_mask |= int'(pend_strobe);
            end
            if (done) begin
                dones++;
                if (k != exp_cyc) done_late++;
            end
        end
        req_valid = 1'b0;
        chk(rq, "strobed core set (R3/R4)", got_mask, exp_mask);
        chk("R5", "scan length", cyc, exp_cyc);
        chk("R5", "ascending order", order_bad, 0);
        chk("R6", "multi strobes", multi, 0);
        chk("R6", "sgi mismatch", sgi_bad, 0);
        chk("R7", "done pulses", dones, (exp_mask != 0) ? 1 : 0);
        chk("R7", "done timing", done_late, 0);
        chk("R8", "ready vs busy", rdy_bad, 0);
        chk("R8", "err during write/busy", errs, 0);
    endtask

    task automatic t_reset;
        chk("R9", "ready", req_ready, 1);
        chk("R9", "busy", busy, 0);
        chk("R9", "strobe", pend_strobe, 0);
        chk("R9", "done", done, 0);
        chk("R9", "err", req_err, 0);
    endtask

    task automatic t_single;       // core 2 only, early exit after 3 cycles
        run_write("R3", mk(4'h5, 1'b0, 16'h0004, 8'd1, 8'd5, 8'h0A, 1'b0), 0, 1'b0);
    endtask

    task automatic t_multi_junk;   // cores 0,1 with ignored bits set (R2)
        run_write("R2", mk(4'hF, 1'b0, 16'h0003, 8'd1, 8'd5, 8'h0A, 1'b1), 5, 1'b0);
    endtask

    task automatic t_mismatch;     // level 2 wrong: nothing matches
        run_write("R3", mk(4'h2, 1'b0, 16'h000F, 8'd1, 8'd6, 8'h0A, 1'b0), 1, 1'b0);
    endtask

    task automatic t_bcast;        // all but sender 3; fields ignored
        run_write("R4", mk(4'h9, 1'b1, 16'h0001, 8'd7, 8'd7, 8'd7, 1'b1), 3, 1'b0);
    endtask

    task automatic t_lvl0_range;   // core 7 level0 19 never matches
        run_write("R10", mk(4'h1, 1'b0, 16'h0008, 8'd2, 8'd5, 8'h0A, 1'b0), 0, 1'b0);
    endtask

    task automatic t_empty_list;   // one-cycle scan, no done
        run_write("R5", mk(4'h3, 1'b0, 16'h0000, 8'd1, 8'd5, 8'h0A, 1'b0), 0, 1'b0);
    endtask

    task automatic t_busy_read;    // reads offered while busy are ignored
        run_write("R8", mk(4'h6, 1'b0, 16'h0004, 8'd1, 8'd5, 8'h0A, 1'b0), 1, 1'b1);
    endtask

    task automatic t_read;
        int errs = 0, bsy = 0, strb = 0, dn = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_data = mk(4'h4, 1'b1, 16'hFFFF, 8'd1, 8'd5, 8'h0A, 1'b0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1", "err pulse", req_err, 1);
        for (int k = 0; k < N + 2; k++) begin
            if (k > 0) @(negedge clk);
            if (k > 0 && req_err) errs++;
            if (busy) bsy++;
            if (pend_strobe != 0) strb++;
            if (done) dn++;
        end
        chk("R1", "err width", errs, 0);
        chk("R1", "no scan", bsy, 0);
        chk("R1", "no strobe", strb, 0);
        chk("R1", "no done", dn, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi_junk();
        t_mismatch();
        t_bcast();
        t_lvl0_range();
        t_empty_list();
        t_busy_read();
        t_read();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule